// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Fill Flags

This block is a first-in, first-out buffer of 64 words, each 9 bits wide. A dual-port storage array with separate write and read pointers holds the words. A producer loads a word by raising a shift-in strobe. A consumer removes the word at the head by raising a shift-out strobe. An input-ready output tells the producer whether a word will be taken. An output-ready output tells the consumer that the data outputs carry a valid word.

The head word is read straight from the array at the read pointer. A word written into an empty buffer therefore appears on the outputs in the cycle after its strobe is seen. Two flags report the fill level: half-full and full. An active-low master reset clears the stored words, the pointers and the count, and it forces the data outputs low. An output-enable input floats the data outputs when it is low.

The design is fully synchronous to one system clock. Each strobe is edge-detected on that clock, so a strobe held high for several cycles moves exactly one word.

Top module: `strobe_fifo`

## Requirements
- R1: While `rstN` is low (asynchronous), `inReady` is 1, `outReady`, `halfFull` and `full` are 0, and with `outEn` high `dataOut` is all zeros.
- R2: A shift-in seen on the first clock edge after `rstN` rises is ignored, and no word is stored.
- R3: An accepted shift-in into an empty buffer makes `outReady` 1, and the written word appears on `dataOut` after that same clock edge.
- R4: Each strobe acts only on a 0-to-1 transition sampled by the clock. A strobe held high for several cycles moves one word.
- R5: `halfFull` is 1 exactly when the stored count is 32 or more.
- R6: At a count of 64, `full` is 1 and `inReady` is 0. A shift-in in that state stores nothing and does not disturb the stored words.
- R7: A shift-out while `outReady` is 0 is ignored. A later write is still read back first.
- R8: Simultaneous shift-in and shift-out on a buffer that is neither empty nor full removes the head, appends the new word and leaves the count unchanged.
- R9: With `outEn` low, all 9 bits of `dataOut` are high-impedance.
- R10: Words leave in the order they were accepted, including when the pointers wrap past the last array location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| shiftIn | input | 1 | Write strobe; acts on its rising transition |
| shiftOut | input | 1 | Read strobe; acts on its rising transition |
| outEn | input | 1 | High drives `dataOut`; low floats it |
| dataIn | input | 9 | Word to be written |
| dataOut | output | 9 | Head word, or high-impedance |
| inReady | output | 1 | A shift-in will be accepted |
| outReady | output | 1 | `dataOut` holds a valid word |
| halfFull | output | 1 | Count is at least half the depth |
| full | output | 1 | Count equals the depth |

## Verification
Some properties are checked on every cycle by the assertions:
- each accepted lone write raises the count by one;
- a paired write and read keeps the count steady;
- a held strobe never produces a second transfer;
- the read-ready output only drops when the last word leaves;
- the write pointer stays put unless a write is accepted.

Other behaviours need the bench's scenarios:
- word ordering across a pointer wrap;
- the single ignored strobe after reset;
- refusal of a write into a full buffer while the stored data stays intact;
- the floating outputs.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ctlStrobes_t;
endpackage

// File: rtl/strobe_fifo_ctl.sv
module strobe_fifo_ctl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftIn,
  input  logic        shiftOut,
  output ctlStrobes_t strb,
  output logic        inReady,
  output logic        outReady,
  output logic        halfFull,
  output logic        full
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic          siPrev, soPrev, recovered;
  logic [CW-1:0] count;
  logic          siRise, soRise;

  assign siRise = shiftIn & ~siPrev;
  assign soRise = shiftOut & ~soPrev;

  assign full     = (count == CW'(DEPTH));
  assign outReady = (count != '0);
  assign halfFull = (count >= CW'(HALF));
  assign inReady  = ~full;

  always_comb begin
    strb.wrEn = siRise & recovered & inReady;
    strb.rdEn = soRise & outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siPrev    <= 1'b0;
      soPrev    <= 1'b0;
      recovered <= 1'b0;
      count     <= '0;
    end else begin
      siPrev    <= shiftIn;
      soPrev    <= shiftOut;
      recovered <= 1'b1;
      case ({strb.wrEn, strb.rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3 / R6: a lone accepted write grows the count by exactly one
  assert_push_counts_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.rdEn) |=> (count == $past(count) + 1'b1));

  // R8: a paired write and read leaves the count unchanged
  assert_swap_keeps_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.rdEn) |=> $stable(count));

  // R4: a strobe held high moves no further word
  assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftIn && $past(shiftIn)) |-> !strb.wrEn);

  // R7: read-ready only drops when the last word leaves
  assert_empty_on_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReady) |-> ($past(count) == CW'(1)));
endmodule

// File: rtl/strobe_fifo_dp.sv
module strobe_fifo_dp
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] headWord
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.wrEn) begin
        mem[wrPtr] <= dataIn;
        wrPtr      <= bump(wrPtr);
      end
      if (strb.rdEn) rdPtr <= bump(rdPtr);
    end
  end

  assign headWord = mem[rdPtr];

  // R6 / R7: refused strobes leave the write pointer untouched
  assert_wrptr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(wrPtr));

  // R10: every accepted read advances the read pointer
  assert_rdptr_moves_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> (rdPtr != $past(rdPtr)));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic             shiftOut,
  input  logic             outEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             inReady,
  output logic             outReady,
  output logic             halfFull,
  output logic             full
);
  ctlStrobes_t      strb;
  logic [WIDTH-1:0] headWord;

  strobe_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .strb(strb), .inReady(inReady), .outReady(outReady),
    .halfFull(halfFull), .full(full)
  );

  strobe_fifo_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .headWord(headWord)
  );

  // R9: output enable floats the data pins
  assign dataOut = outEn ? headWord : {WIDTH{1'bz}};
endmodule

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;
  localparam int DEPTH = 64;
  localparam int WIDTH = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftIn = 1'b0, shiftOut = 1'b0, outEn = 1'b1;
  logic [WIDTH-1:0] dataIn = '0;
  wire  [WIDTH-1:0] dataOut;
  logic inReady, outReady, halfFull, full;

  int checks = 0;
  int fails = 0;
  logic [WIDTH-1:0] expQ[$];

  always #4 clk = ~clk;

  strobe_fifo i_strobe_fifo (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut),
    .outEn(outEn), .dataIn(dataIn), .dataOut(dataOut), .inReady(inReady),
    .outReady(outReady), .halfFull(halfFull), .full(full)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: strobes a word in and records it as expected when it should be accepted
  task automatic pushWord(input logic [WIDTH-1:0] d);
    @(negedge clk);
    if (expQ.size() < DEPTH) expQ.push_back(d);
    dataIn  = d;
    shiftIn = 1'b1;
    @(negedge clk);
    shiftIn = 1'b0;
  endtask

  // monitor: compares the head against the scoreboard, then strobes it out
  task automatic popWord(input string tag);
    @(negedge clk);
    check(outReady == (expQ.size() != 0), tag, outReady, expQ.size() != 0);
    if (expQ.size() != 0) begin
      check(dataOut === expQ[0], tag, dataOut, expQ[0]);
      void'(expQ.pop_front());
    end
    shiftOut = 1'b1;
    @(negedge clk);
    shiftOut = 1'b0;
  endtask

  task automatic drainAll(input string tag);
    while (expQ.size() != 0) popWord(tag);
    @(negedge clk);
    check(outReady == 1'b0, tag, outReady, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(inReady == 1 && outReady == 0 && halfFull == 0 && full == 0, "R1 flags",
          {inReady, outReady, halfFull, full}, 4'b1000);
    check(dataOut === '0, "R1 data low", dataOut, 0);

    // R2: strobe on the first edge after release is dropped
    rstN = 1'b1;
    shiftIn = 1'b1;
    dataIn = 9'h155;
    @(negedge clk);
    shiftIn = 1'b0;
    check(outReady == 1'b0, "R2 recovery", outReady, 0);

    // R3: fall-through into an empty buffer
    @(negedge clk);
    dataIn = 9'h0a5;
    shiftIn = 1'b1;
    expQ.push_back(9'h0a5);
    @(negedge clk);
    shiftIn = 1'b0;
    check(outReady == 1'b1, "R3 ready", outReady, 1);
    check(dataOut === 9'h0a5, "R3 data", dataOut, 9'h0a5);
    drainAll("R3 drain");

    // R4: held strobes move one word each
    @(negedge clk);
    dataIn = 9'h011;
    shiftIn = 1'b1;
    expQ.push_back(9'h011);
    repeat (4) @(negedge clk);
    shiftIn = 1'b0;
    pushWord(9'h022);
    @(negedge clk);
    shiftOut = 1'b1;
    void'(expQ.pop_front());
    repeat (4) @(negedge clk);
    shiftOut = 1'b0;
    check(outReady == 1 && dataOut === 9'h022, "R4 one word per strobe", dataOut, 9'h022);
    drainAll("R4 drain");

    // R7: read on empty ignored
    popWord("R7 empty read");
    pushWord(9'h1c3);
    check(dataOut === 9'h1c3, "R7 head after empty read", dataOut, 9'h1c3);
    drainAll("R7 drain");

    // R5 / R6: fill to capacity
    for (int i = 0; i < DEPTH; i++) begin
      pushWord(WIDTH'(i * 7 + 3));
      if (i == 30) check(halfFull == 0, "R5 count 31", halfFull, 0);
      if (i == 31) check(halfFull == 1, "R5 count 32", halfFull, 1);
      if (i == 62) check(full == 0 && inReady == 1, "R6 count 63", {full, inReady}, 2'b01);
    end
    check(full == 1 && inReady == 0, "R6 full", {full, inReady}, 2'b10);
    pushWord(9'h1ff);
    check(full == 1 && dataOut === 9'h003, "R6 refused write", dataOut, 9'h003);
    for (int i = 0; i < DEPTH / 2 + 1; i++) popWord("R10 order");
    check(halfFull == 0, "R5 below half", halfFull, 0);

    // R8: simultaneous in and out on a partly filled buffer (also wraps pointers)
    @(negedge clk);
    dataIn = 9'h0f0;
    shiftIn = 1'b1;
    shiftOut = 1'b1;
    void'(expQ.pop_front());
    expQ.push_back(9'h0f0);
    @(negedge clk);
    shiftIn = 1'b0;
    shiftOut = 1'b0;
    check(dataOut === expQ[0], "R8 head advanced", dataOut, expQ[0]);
    for (int i = 0; i < 20; i++) pushWord(WIDTH'(9'h100 + i));
    drainAll("R10 wrap order");

    // R9: floating outputs
    pushWord(9'h0aa);
    outEn = 1'b0;
    #1;
    check(dataOut === {WIDTH{1'bz}}, "R9 high-z", dataOut, 9'h1ff);
    outEn = 1'b1;
    #1;
    check(dataOut === 9'h0aa, "R9 re-enabled", dataOut, 9'h0aa);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule